// File: doc/BRIEF.md
# Machine Scratch and Counter Register Unit

This block is the control and status register file for a small 32-bit integer core. It holds two pieces of state: one scratch word for software, and one free-running counter that advances each time the core completes an instruction. The core passes in the raw fields of a CSR-access instruction: the 12-bit register number, the three-bit minor opcode, the source and destination register indices, and the source register value. The block works out which access form the instruction uses, whether a read and a write take place, and what the written value is. In the same cycle it returns the value the destination register receives.

The core raises `step` in each cycle in which an instruction completes, and raises `csr_sel` with it when that instruction is a CSR access. The read path is combinational from the current state. All state changes take effect on the clock edge that ends the step. Three counter register numbers share the single counter. Every register number the block does not know reads as zero, and writes to such a number are discarded.

Top module: `csr_mini`

## Requirements
- R1: After reset, both the scratch word and the counter read as zero.
- R2: Register number 0x340 is the scratch word. It keeps whatever value was last written to it and changes only through CSR writes.
- R3: Register numbers 0xB00, 0xB01 and 0xB02 all read the same counter value.
- R4: The counter rises by exactly one at each edge where `step` is high. It holds its value at every other edge.
- R5: A write of N to 0xB00 replaces the counter, and the increment of that same step still applies, so the next read returns N+1.
- R6: Writes to 0xB01 and 0xB02 leave the counter with only its normal increment.
- R7: Every other register number reads as zero, and writes to it change neither the scratch word nor the counter.
- R8: Minor opcodes 1 and 5 write the new value, 2 and 6 set bits (old OR data), and 3 and 7 clear bits (old AND NOT data).
- R9: Minor opcodes 1, 2 and 3 take the write data from `rs1_val`. Minor opcodes 5, 6 and 7 take it from the 5-bit `rs1_idx` field, zero-extended to 32 bits.
- R10: For a write form (minor opcode 1 or 5) whose `rd_idx` is 0, `rd_we` stays low, and the write still happens.
- R11: For a set or clear form whose `rs1_idx` is 0, nothing is written, and the read still happens with `rd_we` high.
- R12: `rd_data` carries the register value from before any write made by the same step. It is zero whenever `rd_we` is low.
- R13: Minor opcodes 0 and 4 perform neither a read nor a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction completes in this cycle |
| csr_sel | input | 1 | The completing instruction is a CSR access |
| csr_addr | input | 12 | CSR register number |
| funct3 | input | 3 | Minor opcode of the CSR instruction |
| rs1_idx | input | 5 | Source register index, also used as the immediate |
| rd_idx | input | 5 | Destination register index |
| rs1_val | input | 32 | Value of the source register |
| rd_we | output | 1 | The destination register takes `rd_data` |
| rd_data | output | 32 | Value read from the CSR before the write |

## Verification
The bench builds the block with its default 32-bit data width and the default register numbers. This means the counter aliases, the unknown-number path and the full-width set/clear masks on `rs1_val` are all reachable at their real positions. Because the width is full, a write of 0xFFFFFFFF to the counter brings the wrap to zero on the following step within reach. The same holds for bit patterns in the upper half that the 5-bit immediate forms can never touch. A behavioural model in the bench tracks both registers, and a long pseudo-random stretch mixes every minor opcode with known and unknown numbers.

// File: rtl/csr_mini.sv
module csr_mini #(
  parameter int          XLEN      = 32,
  parameter logic [11:0] SCR_NUM   = 12'h340,
  parameter logic [11:0] CNT_NUM   = 12'hB00,
  parameter logic [11:0] CNT_ALT1  = 12'hB01,
  parameter logic [11:0] CNT_ALT2  = 12'hB02
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            csr_sel,
  input  logic [11:0]     csr_addr,
  input  logic [2:0]      funct3,
  input  logic [4:0]      rs1_idx,
  input  logic [4:0]      rd_idx,
  input  logic [XLEN-1:0] rs1_val,
  output logic            rd_we,
  output logic [XLEN-1:0] rd_data
);

  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_SET = 2'd2;
  localparam logic [1:0] OP_CLR = 2'd3;

  logic [XLEN-1:0] scr_q, cnt_q;
  logic [XLEN-1:0] old_val, src, new_val;
  logic [1:0]      op;
  logic            legal, hit_scr, hit_cnt, do_rd, do_wr;

  assign op      = funct3[1:0];
  assign legal   = step && csr_sel && (op != 2'd0);
  assign hit_scr = (csr_addr == SCR_NUM);
  assign hit_cnt = (csr_addr == CNT_NUM) || (csr_addr == CNT_ALT1) || (csr_addr == CNT_ALT2);
  assign src     = funct3[2] ? XLEN'(rs1_idx) : rs1_val;
  assign do_rd   = legal && ((op != OP_WR) || (rd_idx != 5'd0));
  assign do_wr   = legal && ((op == OP_WR) || (rs1_idx != 5'd0));

  always_comb begin
    if (hit_scr)      old_val = scr_q;
    else if (hit_cnt) old_val = cnt_q;
    else              old_val = '0;
  end

  always_comb begin
    case (op)
      OP_SET:  new_val = old_val | src;
      OP_CLR:  new_val = old_val & ~src;
      default: new_val = src;
    endcase
  end

  assign rd_we   = do_rd;
  assign rd_data = do_rd ? old_val : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scr_q <= '0;
      cnt_q <= '0;
    end else if (step) begin
      if (do_wr && hit_scr) scr_q <= new_val;
      if (do_wr && csr_addr == CNT_NUM) cnt_q <= new_val + XLEN'(1);
      else                              cnt_q <= cnt_q + XLEN'(1);
    end
  end

  a_r4_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !step) |=> $stable(cnt_q));

  a_r4_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && step && !(csr_sel && funct3[1:0] != 2'd0 && csr_addr == CNT_NUM))
      |=> cnt_q == $past(cnt_q) + XLEN'(1));

  a_r5_write_then_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && step && csr_sel && funct3 == 3'b001 && csr_addr == CNT_NUM)
      |=> cnt_q == $past(rs1_val) + XLEN'(1));

  a_r2_scratch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !(step && csr_sel && csr_addr == SCR_NUM)) |=> $stable(scr_q));

  a_r13_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel && funct3[1:0] == 2'd0) |-> !rd_we);

  a_r12_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_we |-> rd_data == '0);

  a_r10_we_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (step && csr_sel));

endmodule

// File: tb/csr_mini_bench.sv
module csr_mini_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0, csr_sel = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [2:0]  funct3 = '0;
  logic [4:0]  rs1_idx = '0, rd_idx = '0;
  logic [31:0] rs1_val = '0;
  logic        rd_we;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_scr, m_cnt;

  always #(CLK_P/2) clk = ~clk;

  csr_mini u_csr_mini (
    .clk(clk), .rst_n(rst_n), .step(step), .csr_sel(csr_sel),
    .csr_addr(csr_addr), .funct3(funct3), .rs1_idx(rs1_idx),
    .rd_idx(rd_idx), .rs1_val(rs1_val), .rd_we(rd_we), .rd_data(rd_data)
  );

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a == 12'h340) return m_scr;
    if (a == 12'hB00 || a == 12'hB01 || a == 12'hB02) return m_cnt;
    return 32'h0;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic st, input logic sel, input logic [11:0] a,
                     input logic [2:0] f3, input logic [4:0] r1, input logic [4:0] rd, input logic [31:0] v);
    logic [1:0]  op;
    logic        ok, dr, dw;
    logic [31:0] d, old, nv;
    @(negedge clk);
    step = st; csr_sel = sel; csr_addr = a; funct3 = f3;
    rs1_idx = r1; rd_idx = rd; rs1_val = v;
    #1;
    op  = f3[1:0];
    ok  = st && sel && op != 2'd0;
    d   = f3[2] ? {27'd0, r1} : v;
    dr  = ok && (op != 2'd1 || rd != 0);
    dw  = ok && (op == 2'd1 || r1 != 0);
    old = m_read(a);
    nv  = (op == 2'd2) ? (old | d) : (op == 2'd3) ? (old & ~d) : d;
    check(tag, "rd_we", {31'd0, rd_we}, {31'd0, dr});
    check(tag, "rd_data", rd_data, dr ? old : 32'h0);
    @(posedge clk);
    if (st) begin
      if (dw && a == 12'h340) m_scr = nv;
      if (dw && a == 12'hB00) m_cnt = nv + 1;
      else                    m_cnt = m_cnt + 1;
    end
  endtask

  task automatic idle(input string tag);
    run(tag, 1'b0, 1'b0, 12'h000, 3'b000, 5'd0, 5'd0, 32'h0);
  endtask

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_scr = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state, read with set-form rs1=0 (pure read)
    run("R1", 1, 1, 12'h340, 3'b010, 5'd0, 5'd3, 32'h0);
    run("R1", 1, 1, 12'hB00, 3'b010, 5'd0, 5'd3, 32'h0);
    // R2 scratch write and readback
    run("R2", 1, 1, 12'h340, 3'b001, 5'd1, 5'd4, 32'hDEADBEEF);
    idle("R4"); idle("R4");
    run("R2", 1, 1, 12'h340, 3'b010, 5'd0, 5'd4, 32'h0);
    // R3 aliases
    run("R3", 1, 1, 12'hB01, 3'b010, 5'd0, 5'd4, 32'h0);
    run("R3", 1, 1, 12'hB02, 3'b010, 5'd0, 5'd4, 32'h0);
    // R4 non-CSR steps advance
    run("R4", 1, 0, 12'hB00, 3'b001, 5'd1, 5'd1, 32'h5);
    run("R4", 1, 1, 12'hB00, 3'b010, 5'd0, 5'd4, 32'h0);
    // R5 write N then read N+1
    run("R5", 1, 1, 12'hB00, 3'b001, 5'd2, 5'd4, 32'h00001000);
    run("R5", 1, 1, 12'hB00, 3'b010, 5'd0, 5'd4, 32'h0);
    run("R5", 1, 1, 12'hB00, 3'b001, 5'd2, 5'd4, 32'hFFFFFFFF);
    run("R5", 1, 1, 12'hB00, 3'b010, 5'd0, 5'd4, 32'h0);
    // R6 alias writes ignored
    run("R6", 1, 1, 12'hB01, 3'b001, 5'd2, 5'd4, 32'h12340000);
    run("R6", 1, 1, 12'hB02, 3'b001, 5'd2, 5'd4, 32'h12340000);
    run("R6", 1, 1, 12'hB00, 3'b010, 5'd0, 5'd4, 32'h0);
    // R7 unknown number
    run("R7", 1, 1, 12'h341, 3'b001, 5'd2, 5'd4, 32'hFFFFFFFF);
    run("R7", 1, 1, 12'h341, 3'b010, 5'd0, 5'd4, 32'h0);
    run("R7", 1, 1, 12'h340, 3'b010, 5'd0, 5'd4, 32'h0);
    // R8 set / clear on scratch
    run("R8", 1, 1, 12'h340, 3'b001, 5'd2, 5'd4, 32'h0F0F0000);
    run("R8", 1, 1, 12'h340, 3'b010, 5'd2, 5'd4, 32'h000000FF);
    run("R8", 1, 1, 12'h340, 3'b011, 5'd2, 5'd4, 32'h0F000001);
    run("R8", 1, 1, 12'h340, 3'b010, 5'd0, 5'd4, 32'h0);
    // R9 immediate forms use rs1_idx
    run("R9", 1, 1, 12'h340, 3'b101, 5'd21, 5'd4, 32'hFFFFFFFF);
    run("R9", 1, 1, 12'h340, 3'b110, 5'd8, 5'd4, 32'hFFFFFFFF);
    run("R9", 1, 1, 12'h340, 3'b111, 5'd1, 5'd4, 32'hFFFFFFFF);
    run("R9", 1, 1, 12'h340, 3'b010, 5'd0, 5'd4, 32'h0);
    // R10 write with rd=x0
    run("R10", 1, 1, 12'h340, 3'b001, 5'd2, 5'd0, 32'hCAFE0001);
    run("R10", 1, 1, 12'h340, 3'b101, 5'd0, 5'd0, 32'h0);
    run("R10", 1, 1, 12'h340, 3'b010, 5'd0, 5'd4, 32'h0);
    // R11 set/clear with rs1 field zero
    run("R11", 1, 1, 12'h340, 3'b011, 5'd0, 5'd4, 32'hFFFFFFFF);
    run("R11", 1, 1, 12'h340, 3'b110, 5'd0, 5'd0, 32'hFFFFFFFF);
    run("R11", 1, 1, 12'h340, 3'b010, 5'd0, 5'd4, 32'h0);
    // R12 read returns pre-write value
    run("R12", 1, 1, 12'h340, 3'b001, 5'd2, 5'd4, 32'h11111111);
    run("R12", 1, 1, 12'h340, 3'b001, 5'd2, 5'd4, 32'h22222222);
    // R13 minor opcodes 0 and 4
    run("R13", 1, 1, 12'h340, 3'b000, 5'd2, 5'd4, 32'h0);
    run("R13", 1, 1, 12'h340, 3'b100, 5'd2, 5'd4, 32'h0);
    run("R13", 1, 1, 12'h340, 3'b010, 5'd0, 5'd4, 32'h0);
    // R12 mixed pseudo-random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      logic [11:0] a;
      r = $urandom;
      case (r[2:0])
        3'd0, 3'd1: a = 12'h340;
        3'd2: a = 12'hB00;
        3'd3: a = 12'hB01;
        3'd4: a = 12'hB02;
        default: a = 12'(r[31:20]);
      endcase
      run("R12", r[3] | r[4], r[5] | r[6], a, r[9:7], (r[10] ? r[15:11] : 5'd0),
          (r[16] ? r[21:17] : 5'd0), $urandom);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule